// File: doc/BRIEF.md
# Mains-Clocked BCD Calendar Counter

This block keeps time of day and a full calendar without a crystal. It counts rising edges of a slow digital line clock (50 Hz or 60 Hz mains-derived), divides them down to one tick per second, and advances packed-BCD counters for seconds, minutes, hours (24-hour), day of week, day of month, month, year, and a 2-bit binary century code. Month lengths, including February in leap years, are handled without software help.

Two copies of the calendar exist. The internal copy always counts. The visible copy is what the output ports show, and a freeze input from the bus side holds it steady while a multi-byte read is in progress. A parallel load writes every field at once and restarts the second divider from zero. Configuration bits choose the divisor, stop timekeeping, and gate a 1 Hz square wave.

Top module: `mains_calendar`

## Requirements
- R1: After reset the divisor select is 1 (divide by 60), the stop bit is 0, the square-wave enable is 0, and the calendar reads 00:00:00, weekday 1, date 01, month 01, year 00, century 0 on the outputs.
- R2: Each second tick happens after 50 rising edges of `line_in` when the select is 0 and after 60 when it is 1. Changing the select through a config write restarts the divider from zero.
- R3: Seconds and minutes count 00 to 59 and hours 00 to 23 in packed BCD (upper nibble tens, lower nibble units), each carrying into the next field when it wraps.
- R4: Day of week counts 1 to 7 and goes from 7 back to 1 at each midnight.
- R5: The date wraps to 01 after 30 in April, June, September and November, and after 31 in the other months except February. December rolls over to month 01.
- R6: February has 29 days when the year is divisible by 4, except that year 00 is a leap year only when the century code is 0; otherwise it has 28.
- R7: When the year wraps from 99 to 00 the century code increments in binary, wrapping from 3 to 0. It changes at no other time except a load.
- R8: While the stop bit is 1, no field of the calendar changes except through a load. Clearing the stop bit resumes counting.
- R9: A load pulse writes all eight fields from the load ports at the next clock edge and resets the second divider to zero, so the next tick comes a full second later.
- R10: While `freeze` is high the output fields hold their value; the internal calendar keeps counting, and the outputs catch up one clock after `freeze` falls.
- R11: With the enable at 1, `sqw_o` is high during the first half of each second (divider count below half the divisor) and low during the second half; with the enable at 0 it stays low.
- R12: The config inputs take effect only on a cycle with `cfg_we` high; at other times they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Slow digital line clock, 50 or 60 Hz, asynchronous |
| cfg_we | input | 1 | Config write strobe |
| cfg_stop | input | 1 | Stop bit value to write |
| cfg_sel60 | input | 1 | Divisor select value (0: /50, 1: /60) |
| cfg_sqw_en | input | 1 | Square-wave enable value |
| load_en | input | 1 | Parallel load strobe for all fields |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load |
| ld_wday | input | 3 | Day of week to load (1-7) |
| ld_date | input | 8 | BCD day of month to load |
| ld_month | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| ld_cent | input | 2 | Century code to load |
| freeze | input | 1 | Holds the visible copy while high |
| sec_o | output | 8 | Visible BCD seconds |
| min_o | output | 8 | Visible BCD minutes |
| hour_o | output | 8 | Visible BCD hours |
| wday_o | output | 3 | Visible day of week |
| date_o | output | 8 | Visible BCD day of month |
| month_o | output | 8 | Visible BCD month |
| year_o | output | 8 | Visible BCD year |
| cent_o | output | 2 | Visible century code |
| sqw_o | output | 1 | Gated 1 Hz square wave |

## Verification
The pairing that matters most is a second tick landing in the same cycle as a load, a divisor change or a freeze edge. The bench keeps its own behavioural model of the line-clock synchroniser, divider and calendar in integers and compares every output at each clock, so a load that arrives mid-second or a freeze lifted right after a tick is judged against where the model says the counters and the square-wave phase should sit. Directed scenarios place the calendar a second before midnight on month, year and century boundaries, and before February rollovers with century codes 0 and nonzero, so the carry chain through all fields happens in one tick.

// File: rtl/mc_cal_pkg.sv
package mc_cal_pkg;

    typedef logic [7:0] bcd8_t;

    typedef struct packed {
        logic [1:0] cent;
        bcd8_t      year;
        bcd8_t      month;
        bcd8_t      date;
        logic [2:0] wday;
        bcd8_t      hours;
        bcd8_t      mins;
        bcd8_t      secs;
    } cal_t;

    localparam cal_t CAL_RESET = '{cent: 2'd0, year: 8'h00, month: 8'h01,
                                   date: 8'h01, wday: 3'd1, hours: 8'h00,
                                   mins: 8'h00, secs: 8'h00};

    localparam bcd8_t SEC_TOP   = 8'h59;
    localparam bcd8_t HOUR_TOP  = 8'h23;
    localparam bcd8_t MONTH_TOP = 8'h12;
    localparam bcd8_t YEAR_TOP  = 8'h99;
    localparam logic [2:0] WDAY_TOP = 3'd7;

    function automatic bcd8_t bcd_inc(bcd8_t v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisible by 4 in BCD: even tens need units 0/4/8, odd tens need 2/6.
    function automatic logic year_div4(bcd8_t y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic is_leap(bcd8_t y, logic [1:0] c);
        if (y == 8'h00)
            return c == 2'd0;
        return year_div4(y);
    endfunction

    function automatic bcd8_t last_day(bcd8_t m, bcd8_t y, logic [1:0] c);
        case (m)
            8'h02:                      return is_leap(y, c) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/mc_prescaler.sv
module mc_prescaler #(
    parameter int DIV_LO   = 50,
    parameter int DIV_HI   = 60,
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic sel_hi,
    input  logic stop,
    input  logic restart,
    output logic tick,
    output logic first_half
);
    localparam int CW = $clog2(DIV_HI + 1);
    localparam logic [CW-1:0] LIM_LO  = CW'(DIV_LO - 1);
    localparam logic [CW-1:0] LIM_HI  = CW'(DIV_HI - 1);
    localparam logic [CW-1:0] HALF_LO = CW'(DIV_LO / 2);
    localparam logic [CW-1:0] HALF_HI = CW'(DIV_HI / 2);

    logic [SYNC_LEN-1:0] sync_q;
    logic                prev_q;
    logic                edge_seen;
    logic [CW-1:0]       cnt_q;
    logic [CW-1:0]       lim;
    logic [CW-1:0]       half;
    logic                at_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], line_in};
            prev_q <= sync_q[SYNC_LEN-1];
        end
    end

    assign edge_seen = sync_q[SYNC_LEN-1] & ~prev_q;
    assign lim       = sel_hi ? LIM_HI : LIM_LO;
    assign half      = sel_hi ? HALF_HI : HALF_LO;
    assign at_lim    = (cnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt_q <= '0;
        else if (edge_seen && !stop)
            cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
    end

    assign tick       = edge_seen & ~stop & at_lim;
    assign first_half = (cnt_q < half);

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim);

    assert_tick_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/mc_cal_core.sv
module mc_cal_core
    import mc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  cal_t load_val,
    output cal_t cur
);
    cal_t nxt;

    always_comb begin
        nxt = cur;
        if (load) begin
            nxt = load_val;
        end else if (tick) begin
            if (cur.secs >= SEC_TOP) begin
                nxt.secs = 8'h00;
                if (cur.mins >= SEC_TOP) begin
                    nxt.mins = 8'h00;
                    if (cur.hours >= HOUR_TOP) begin
                        nxt.hours = 8'h00;
                        nxt.wday  = (cur.wday >= WDAY_TOP) ? 3'd1 : cur.wday + 3'd1;
                        if (cur.date >= last_day(cur.month, cur.year, cur.cent)) begin
                            nxt.date = 8'h01;
                            if (cur.month >= MONTH_TOP) begin
                                nxt.month = 8'h01;
                                if (cur.year >= YEAR_TOP) begin
                                    nxt.year = 8'h00;
                                    nxt.cent = cur.cent + 2'd1;
                                end else begin
                                    nxt.year = bcd_inc(cur.year);
                                end
                            end else begin
                                nxt.month = bcd_inc(cur.month);
                            end
                        end else begin
                            nxt.date = bcd_inc(cur.date);
                        end
                    end else begin
                        nxt.hours = bcd_inc(cur.hours);
                    end
                end else begin
                    nxt.mins = bcd_inc(cur.mins);
                end
            end else begin
                nxt.secs = bcd_inc(cur.secs);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= CAL_RESET;
        else
            cur <= nxt;
    end

    assert_wday_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cur.secs == 8'h59 && cur.mins == 8'h59 &&
         cur.hours == 8'h23 && cur.wday == 3'd7) |=> (cur.wday == 3'd1));

    assert_century_step_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cur.cent == $past(cur.cent) || cur.year == 8'h00));

endmodule

// File: rtl/mc_view.sv
module mc_view
    import mc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic freeze,
    input  cal_t src,
    output cal_t vis
);
    always_ff @(posedge clk) begin
        if (rst)
            vis <= CAL_RESET;
        else if (!freeze)
            vis <= src;
    end

    assert_freeze_hold_R10: assert property (@(posedge clk) disable iff (rst)
        freeze |=> $stable(vis));

endmodule

// File: rtl/mains_calendar.sv
module mains_calendar
    import mc_cal_pkg::*;
#(
    parameter int DIV_LO = 50,
    parameter int DIV_HI = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    input  logic       cfg_we,
    input  logic       cfg_stop,
    input  logic       cfg_sel60,
    input  logic       cfg_sqw_en,
    input  logic       load_en,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [2:0] ld_wday,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    input  logic [1:0] ld_cent,
    input  logic       freeze,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [2:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [1:0] cent_o,
    output logic       sqw_o
);
    logic stop_q, sel_q, sqw_en_q;
    logic restart, tick, first_half;
    cal_t load_val, cal_int, cal_vis;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop_q   <= 1'b0;
            sel_q    <= 1'b1;
            sqw_en_q <= 1'b0;
        end else if (cfg_we) begin
            stop_q   <= cfg_stop;
            sel_q    <= cfg_sel60;
            sqw_en_q <= cfg_sqw_en;
        end
    end

    assign restart = load_en | (cfg_we & (cfg_sel60 != sel_q));

    assign load_val = '{cent: ld_cent, year: ld_year, month: ld_month,
                        date: ld_date, wday: ld_wday, hours: ld_hour,
                        mins: ld_min, secs: ld_sec};

    mc_prescaler #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .SYNC_LEN(2)) u_div (
        .clk        (clk),
        .rst        (rst),
        .line_in    (line_in),
        .sel_hi     (sel_q),
        .stop       (stop_q),
        .restart    (restart),
        .tick       (tick),
        .first_half (first_half)
    );

    mc_cal_core u_core (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load_en),
        .load_val (load_val),
        .cur      (cal_int)
    );

    mc_view u_view (
        .clk    (clk),
        .rst    (rst),
        .freeze (freeze),
        .src    (cal_int),
        .vis    (cal_vis)
    );

    assign sec_o   = cal_vis.secs;
    assign min_o   = cal_vis.mins;
    assign hour_o  = cal_vis.hours;
    assign wday_o  = cal_vis.wday;
    assign date_o  = cal_vis.date;
    assign month_o = cal_vis.month;
    assign year_o  = cal_vis.year;
    assign cent_o  = cal_vis.cent;
    assign sqw_o   = sqw_en_q & first_half;

    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !load_en) |=> $stable(cal_int));

    assert_load_take_R9: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cal_int.secs == $past(ld_sec) && cal_int.year == $past(ld_year)
                     && cal_int.cent == $past(ld_cent)));

    assert_sqw_after_tick_R11: assert property (@(posedge clk) disable iff (rst)
        (tick && sqw_en_q && !cfg_we) |=> sqw_o);

endmodule

// File: tb/tb_mains_calendar.sv
module tb_mains_calendar;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b0;
    logic cfg_we = 0, cfg_stop = 0, cfg_sel60 = 1, cfg_sqw_en = 0;
    logic load_en = 0;
    logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_date = 8'h01;
    logic [7:0] ld_month = 8'h01, ld_year = 0;
    logic [2:0] ld_wday = 3'd1;
    logic [1:0] ld_cent = 0;
    logic freeze = 0;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
    logic [2:0] wday_o;
    logic [1:0] cent_o;
    logic sqw_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mains_calendar dut (
        .clk(clk), .rst(rst), .line_in(line_in),
        .cfg_we(cfg_we), .cfg_stop(cfg_stop), .cfg_sel60(cfg_sel60), .cfg_sqw_en(cfg_sqw_en),
        .load_en(load_en), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_wday(ld_wday), .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
        .ld_cent(ld_cent), .freeze(freeze),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o),
        .sqw_o(sqw_o)
    );

    function automatic int bcd2i(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int month_days(int mo, int y, int c);
        bit leap;
        leap = (y % 4 == 0) && (y != 0 || c == 0);
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // Behavioural reference model
    int ms, mm, mh, mwd, md, mmo, my, mc;
    int vs, vm, vh, vwd, vd, vmo, vy, vc;
    int m_cnt;
    bit m_s1, m_s2, m_s3, m_stop, m_sel, m_en;

    always @(posedge clk) begin
        bit e, tk, rs;
        int div;
        if (rst) begin
            ms = 0; mm = 0; mh = 0; mwd = 1; md = 1; mmo = 1; my = 0; mc = 0;
            vs = 0; vm = 0; vh = 0; vwd = 1; vd = 1; vmo = 1; vy = 0; vc = 0;
            m_cnt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_stop = 0; m_sel = 1; m_en = 0;
        end else begin
            e = m_s2 && !m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = line_in;
            div = m_sel ? 60 : 50;
            tk = e && !m_stop && (m_cnt == div - 1);
            if (!freeze) begin
                vs = ms; vm = mm; vh = mh; vwd = mwd; vd = md; vmo = mmo; vy = my; vc = mc;
            end
            rs = load_en || (cfg_we && (cfg_sel60 != m_sel));
            if (rs) m_cnt = 0;
            else if (e && !m_stop) m_cnt = (m_cnt == div - 1) ? 0 : m_cnt + 1;
            if (load_en) begin
                ms = bcd2i(ld_sec); mm = bcd2i(ld_min); mh = bcd2i(ld_hour);
                mwd = int'(ld_wday); md = bcd2i(ld_date); mmo = bcd2i(ld_month);
                my = bcd2i(ld_year); mc = int'(ld_cent);
            end else if (tk) begin
                ms++;
                if (ms == 60) begin
                    ms = 0; mm++;
                    if (mm == 60) begin
                        mm = 0; mh++;
                        if (mh == 24) begin
                            mh = 0;
                            mwd = (mwd == 7) ? 1 : mwd + 1;
                            if (md >= month_days(mmo, my, mc)) begin
                                md = 1; mmo++;
                                if (mmo == 13) begin
                                    mmo = 1; my++;
                                    if (my == 100) begin
                                        my = 0; mc = (mc + 1) % 4;
                                    end
                                end
                            end else md++;
                        end
                    end
                end
            end
            if (cfg_we) begin
                m_stop = cfg_stop; m_sel = cfg_sel60; m_en = cfg_sqw_en;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison with the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3 sec",   int'(sec_o),   int'(i2bcd(vs)));
            chk("R3 min",   int'(min_o),   int'(i2bcd(vm)));
            chk("R3 hour",  int'(hour_o),  int'(i2bcd(vh)));
            chk("R4 wday",  int'(wday_o),  vwd);
            chk("R5 date",  int'(date_o),  int'(i2bcd(vd)));
            chk("R6 month", int'(month_o), int'(i2bcd(vmo)));
            chk("R7 year",  int'(year_o),  int'(i2bcd(vy)));
            chk("R7 cent",  int'(cent_o),  vc);
            chk("R11 sqw",  int'(sqw_o),   int'(m_en && (m_cnt < (m_sel ? 30 : 25))));
        end
    end

    // Line clock: a rising edge every 4 system clocks
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            line_in = ~line_in;
        end
    end

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(int h, int m, int s, int wd, int d, int mo, int y, int c);
        @(negedge clk);
        ld_hour = i2bcd(h); ld_min = i2bcd(m); ld_sec = i2bcd(s);
        ld_wday = 3'(wd); ld_date = i2bcd(d); ld_month = i2bcd(mo);
        ld_year = i2bcd(y); ld_cent = 2'(c);
        load_en = 1;
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic do_cfg(bit st, bit s60, bit en);
        @(negedge clk);
        cfg_stop = st; cfg_sel60 = s60; cfg_sqw_en = en; cfg_we = 1;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        int highs;
        waitc(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset sec",   int'(sec_o), 0);
        chk("R1 reset wday",  int'(wday_o), 1);
        chk("R1 reset date",  int'(date_o), 8'h01);
        chk("R1 reset month", int'(month_o), 8'h01);
        chk("R1 reset sqw",   int'(sqw_o), 0);
        // R1 divisor defaults to 60: two ticks in 700 cycles
        do_load(0, 0, 0, 1, 1, 1, 0, 0);
        waitc(700);
        chk("R1 default div60", int'(sec_o), 8'h02);

        // R2 divide by 50: three ticks in 700 cycles
        do_cfg(0, 0, 0);
        do_load(0, 0, 10, 1, 1, 1, 0, 0);
        waitc(700);
        chk("R2 div50", int'(sec_o), 8'h13);
        do_cfg(0, 1, 0);

        // R4 R5 R7 full carry at year 99 century 3
        do_load(23, 59, 58, 7, 31, 12, 99, 3);
        waitc(760);
        chk("R3 midnight sec",  int'(sec_o), 8'h01);
        chk("R3 midnight hour", int'(hour_o), 8'h00);
        chk("R4 wday 7->1",     int'(wday_o), 1);
        chk("R5 dec31->01",     int'(date_o), 8'h01);
        chk("R5 month wrap",    int'(month_o), 8'h01);
        chk("R7 year wrap",     int'(year_o), 8'h00);
        chk("R7 cent 3->0",     int'(cent_o), 0);

        // R6 leap rules
        do_load(23, 59, 59, 2, 28, 2, 24, 1);
        waitc(300);
        chk("R6 leap yr24", int'(date_o), 8'h29);
        do_load(23, 59, 59, 2, 28, 2, 0, 0);
        waitc(300);
        chk("R6 yr00 cent0 leap", int'(date_o), 8'h29);
        do_load(23, 59, 59, 2, 28, 2, 0, 2);
        waitc(300);
        chk("R6 yr00 cent2 not leap", int'(month_o), 8'h03);
        do_load(23, 59, 59, 2, 28, 2, 23, 0);
        waitc(300);
        chk("R6 yr23 not leap", int'(date_o), 8'h01);

        // R5 30-day month
        do_load(23, 59, 59, 3, 30, 4, 5, 0);
        waitc(300);
        chk("R5 apr30->may01", int'(month_o), 8'h05);

        // R7 year 99 with century 1 -> 2
        do_load(23, 59, 59, 3, 31, 12, 99, 1);
        waitc(300);
        chk("R7 cent 1->2", int'(cent_o), 2);

        // R8 stop
        do_cfg(1, 1, 0);
        do_load(12, 34, 56, 4, 15, 6, 10, 0);
        waitc(600);
        chk("R8 stopped", int'(sec_o), 8'h56);
        do_cfg(0, 1, 0);
        waitc(300);
        chk("R8 resumed", int'(sec_o), 8'h57);

        // R9 load mid-second restarts divider
        waitc(97);
        do_load(5, 5, 5, 1, 1, 1, 1, 0);
        waitc(230);
        chk("R9 no early tick", int'(sec_o), 8'h05);
        waitc(25);
        chk("R9 tick after full second", int'(sec_o), 8'h06);

        // R10 freeze
        do_load(10, 0, 0, 1, 1, 1, 1, 0);
        @(negedge clk);
        freeze = 1;
        waitc(600);
        chk("R10 frozen", int'(sec_o), 8'h00);
        freeze = 0;
        waitc(3);
        chk("R10 caught up", int'(sec_o), 8'h02);

        // R12 config ignored without write strobe
        cfg_stop = 1; cfg_sel60 = 0; cfg_sqw_en = 1;
        do_load(1, 1, 1, 1, 1, 1, 1, 0);
        waitc(300);
        chk("R12 ignored stop", int'(sec_o), 8'h02);
        chk("R12 ignored sqw", int'(sqw_o), 0);

        // R11 square wave
        highs = 0;
        for (int i = 0; i < 480; i++) begin
            @(negedge clk);
            highs += int'(sqw_o);
        end
        chk("R11 disabled low", highs, 0);
        do_cfg(0, 1, 1);
        waitc(20);
        highs = 0;
        for (int i = 0; i < 480; i++) begin
            @(negedge clk);
            highs += int'(sqw_o);
        end
        chk("R11 half duty", highs, 240);

        // R2 select change restarts divider
        do_cfg(0, 0, 1);
        chk("R2 restart sqw high", int'(sqw_o), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule